// File: doc/BRIEF.md
# Drive Control Register

This block is the host-writable control register of a floppy-style disk interface. The host writes one byte at a fixed I/O address. That byte names the active drive, switches the spindle motors, holds or releases the controller core's reset, and opens or closes the DMA and interrupt paths between the core and the host bus. Reading the same address returns the byte as it was last written.

The low two bits hold a drive number, which is decoded into one-hot select lines. Two motor bits drive two motor outputs. An active-low reset bit feeds a small two-state sequencer (HELD, RUN), and that sequencer drives a registered level reset to the core. A mode input picks how the DMA and interrupt paths are gated. In gated mode, the enable bit decides whether DRQ is driven or left at high impedance, and whether DACK, TC and the interrupt get through. In open mode, all four paths pass at all times, even while hardware reset is asserted.

The core's reset, as driven by this block, never clears this register. A hardware reset is the only thing that clears it.

Top module: `drvctl_reg`

## Requirements
- R1: While `rst_n` is low the stored byte becomes 00h. After reset, a read returns 00h, `drv_sel` is 0001b, `motor_on` is 00b, `core_rst` is 1, and in gated mode `drq_oe` is 0.
- R2: A write with `io_wr`=1 and `io_addr` equal to BASE_ADDR (3F2h) stores `io_wdata` at that clock edge, at any time. A write to any other address leaves the stored byte unchanged.
- R3: `drv_sel[n]` is 1 exactly when stored bits 1:0 equal n, so exactly one select line is high at all times.
- R4: `motor_on[0]` follows stored bit 4 and `motor_on[1]` follows stored bit 5, with 1 meaning the motor is on. Stored bits 6 and 7 reach no output, but they are returned on read.
- R5: `core_rst` is 1 from the edge that stores bit 2 as 0 until the edge that stores bit 2 as 1. Writing 0 and then 1 on back-to-back cycles gives a `core_rst` pulse of exactly one clock.
- R6: While `core_rst` is 1, the stored byte and all outputs decoded from it keep the values last written.
- R7: In gated mode (`mode_open`=0) with stored bit 3 at 0: `drq_oe`=0, `drq_out`=0, `dack_n_out`=1, `tc_out`=0 and `intr_out`=0, whatever the raw inputs are.
- R8: In gated mode with stored bit 3 at 1: `drq_oe`=1, and `drq_out`, `dack_n_out`, `tc_out` and `intr_out` follow `drq_in`, `dack_n_in`, `tc_in` and `intr_in`.
- R9: In open mode (`mode_open`=1), `drq_oe`=1 and all four paths follow their raw inputs whatever bit 3 holds. This includes the time while `rst_n` is low and the time while `core_rst` is 1.
- R10: Writing 1Ch selects drive 0 with motor 0 on. Writing 2Dh selects drive 1 with motor 1 on. In both cases DMA is enabled and `core_rst` is 0.
- R11: `io_rdata` shows the stored byte while `io_rd`=1 and the address matches. At all other times it is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| io_addr | input | 10 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 00h when not selected |
| mode_open | input | 1 | 1 = DMA and interrupt paths always open, 0 = gated by bit 3 |
| drq_in | input | 1 | DMA request from the core |
| dack_n_in | input | 1 | DMA acknowledge from the host, active low |
| tc_in | input | 1 | Terminal count from the host |
| intr_in | input | 1 | Interrupt from the core |
| drv_sel | output | 4 | One-hot drive select |
| motor_on | output | 2 | Motor enables |
| core_rst | output | 1 | Registered level reset to the core |
| drq_out | output | 1 | Gated DMA request |
| drq_oe | output | 1 | Output enable for the DRQ pad (0 = high impedance) |
| dack_n_out | output | 1 | Gated DMA acknowledge to the core, active low |
| tc_out | output | 1 | Gated terminal count to the core |
| intr_out | output | 1 | Gated interrupt to the host |

## Verification
The only state in this block is the stored byte and the reset sequencer. Any corruption of either shows up at the ports on the next half clock after the write edge that caused it: a wrong select line, a wrong motor line, a `core_rst` level that disagrees with bit 2, or a DMA or interrupt path gated the wrong way. A readback exposes bits 6 and 7 and any missed or misaddressed write in the same cycle as the read strobe. The back-to-back reset sequence and the hardware-reset window in open mode are the two timing corners, and the bench checks them directly.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;

    // Field positions within the stored control byte.
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned F_SEL_LSB   = 0;
    localparam int unsigned F_RUN_N     = 2;   // 0 = core held in reset
    localparam int unsigned F_DMA_EN    = 3;
    localparam int unsigned F_MOT_LSB   = 4;

    // Reset sequencer states.
    typedef enum logic [0:0] {
        ST_HELD = 1'b0,   // core held in reset
        ST_RUN  = 1'b1    // core running
    } seq_state_e;

endpackage

// File: rtl/drvctl_store.sv
module drvctl_store #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] q,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_hit;

    always_comb begin
        addr_hit = (io_addr == BASE_ADDR);
        wr_hit   = io_wr && addr_hit;
        rd_hit   = io_rd && addr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_hit) begin
            q <= io_wdata;
        end
    end

endmodule

// File: rtl/drvctl_rst_seq.sv
module drvctl_rst_seq
    import drvctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic run_n_wr,
    output logic core_rst
);

    seq_state_e state_q;
    seq_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RELEASE (HELD -> RUN) and ENGAGE (RUN -> HELD).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: if (wr_hit && run_n_wr)  state_d = ST_RUN;
            ST_RUN:  if (wr_hit && !run_n_wr) state_d = ST_HELD;
        endcase
    end

    // Output is decoded from the state flop only, so it cannot glitch.
    always_comb begin
        unique case (state_q)
            ST_HELD: core_rst = 1'b1;
            ST_RUN:  core_rst = 1'b0;
        endcase
    end

endmodule

// File: rtl/drvctl_decode.sv
module drvctl_decode #(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned NUM_MOTORS = 2,
    localparam int unsigned SEL_W     = $clog2(NUM_DRIVES)
) (
    input  logic [SEL_W-1:0]      sel_code,
    input  logic [NUM_MOTORS-1:0] mot_bits,
    output logic [NUM_DRIVES-1:0] drv_sel,
    output logic [NUM_MOTORS-1:0] motor_on
);

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_sel
        assign drv_sel[g] = (sel_code == SEL_W'(g));
    end

    for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_mot
        assign motor_on[m] = mot_bits[m];
    end

endmodule

// File: rtl/drvctl_gate.sv
module drvctl_gate (
    input  logic mode_open,
    input  logic dma_en_bit,
    input  logic drq_in,
    input  logic dack_n_in,
    input  logic tc_in,
    input  logic intr_in,
    output logic drq_out,
    output logic drq_oe,
    output logic dack_n_out,
    output logic tc_out,
    output logic intr_out
);

    logic path_open;

    always_comb begin
        path_open  = mode_open || dma_en_bit;
        drq_oe     = path_open;
        drq_out    = path_open && drq_in;
        dack_n_out = path_open ? dack_n_in : 1'b1;
        tc_out     = path_open && tc_in;
        intr_out   = path_open && intr_in;
    end

endmodule

// File: rtl/drvctl_reg.sv
module drvctl_reg
    import drvctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3F2,
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned NUM_MOTORS = 2,
    localparam int unsigned SEL_W     = $clog2(NUM_DRIVES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [BYTE_W-1:0]     io_wdata,
    output logic [BYTE_W-1:0]     io_rdata,
    input  logic                  mode_open,
    input  logic                  drq_in,
    input  logic                  dack_n_in,
    input  logic                  tc_in,
    input  logic                  intr_in,
    output logic [NUM_DRIVES-1:0] drv_sel,
    output logic [NUM_MOTORS-1:0] motor_on,
    output logic                  core_rst,
    output logic                  drq_out,
    output logic                  drq_oe,
    output logic                  dack_n_out,
    output logic                  tc_out,
    output logic                  intr_out
);

    logic [BYTE_W-1:0] dor_q;
    logic              wr_hit;
    logic              rd_hit;

    drvctl_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (BYTE_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .q        (dor_q),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    drvctl_rst_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .run_n_wr (io_wdata[F_RUN_N]),
        .core_rst (core_rst)
    );

    drvctl_decode #(
        .NUM_DRIVES (NUM_DRIVES),
        .NUM_MOTORS (NUM_MOTORS)
    ) u_dec (
        .sel_code (dor_q[F_SEL_LSB +: SEL_W]),
        .mot_bits (dor_q[F_MOT_LSB +: NUM_MOTORS]),
        .drv_sel  (drv_sel),
        .motor_on (motor_on)
    );

    drvctl_gate u_gate (
        .mode_open  (mode_open),
        .dma_en_bit (dor_q[F_DMA_EN]),
        .drq_in     (drq_in),
        .dack_n_in  (dack_n_in),
        .tc_in      (tc_in),
        .intr_in    (intr_in),
        .drq_out    (drq_out),
        .drq_oe     (drq_oe),
        .dack_n_out (dack_n_out),
        .tc_out     (tc_out),
        .intr_out   (intr_out)
    );

    // Read path: the full byte, including bits with no output.
    always_comb begin
        io_rdata = rd_hit ? dor_q : '0;
    end

endmodule

// File: rtl/drvctl_reg_chk.sv
module drvctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] io_wdata,
    input logic       wr_hit,
    input logic [7:0] dor_q,
    input logic [3:0] drv_sel,
    input logic [1:0] motor_on,
    input logic       core_rst,
    input logic       mode_open,
    input logic       drq_in,
    input logic       intr_in,
    input logic       drq_oe,
    input logic       drq_out,
    input logic       dack_n_out,
    input logic       tc_out,
    input logic       intr_out
);

    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (dor_q == $past(io_wdata)));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(dor_q));

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv_sel) == 1);

    assert_motor_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        motor_on == dor_q[5:4]);

    assert_core_rst_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst == !dor_q[2]);

    assert_core_rst_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(wr_hit));

    assert_gated_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_open && !dor_q[3]) |-> (!drq_oe && !drq_out && dack_n_out && !tc_out && !intr_out));

    assert_open_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_open |-> (drq_oe && (drq_out == drq_in) && (intr_out == intr_in)));

endmodule

bind drvctl_reg drvctl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wdata   (io_wdata),
    .wr_hit     (wr_hit),
    .dor_q      (dor_q),
    .drv_sel    (drv_sel),
    .motor_on   (motor_on),
    .core_rst   (core_rst),
    .mode_open  (mode_open),
    .drq_in     (drq_in),
    .intr_in    (intr_in),
    .drq_oe     (drq_oe),
    .drq_out    (drq_out),
    .dack_n_out (dack_n_out),
    .tc_out     (tc_out),
    .intr_out   (intr_out)
);

// File: tb/drvctl_reg_bench.sv
`timescale 1ns/1ps
module drvctl_reg_bench;

    localparam logic [9:0] BASE = 10'h3F2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] io_addr = BASE;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       mode_open = 1'b0;
    logic       drq_in = 1'b0;
    logic       dack_n_in = 1'b1;
    logic       tc_in = 1'b0;
    logic       intr_in = 1'b0;
    logic [3:0] drv_sel;
    logic [1:0] motor_on;
    logic       core_rst, drq_out, drq_oe, dack_n_out, tc_out, intr_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    drvctl_reg u_drvctl_reg (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mode_open(mode_open),
        .drq_in(drq_in), .dack_n_in(dack_n_in), .tc_in(tc_in), .intr_in(intr_in),
        .drv_sel(drv_sel), .motor_on(motor_on), .core_rst(core_rst),
        .drq_out(drq_out), .drq_oe(drq_oe), .dack_n_out(dack_n_out),
        .tc_out(tc_out), .intr_out(intr_out)
    );

    // Vector: {wdata[7:0], mode_open, raw{drq,dack_n,tc,intr},
    //          expected{sel[3:0], motor[1:0], core_rst, oe, drq, dack_n, tc, intr}}
    localparam logic [24:0] VEC [0:7] = '{
        {8'h1C, 1'b0, 4'b1011, 12'b0001_01_0_1_1_0_1_1},  // R10 R8 drive 0
        {8'h2D, 1'b0, 4'b1011, 12'b0010_10_0_1_1_0_1_1},  // R10 R8 drive 1
        {8'h06, 1'b0, 4'b1011, 12'b0100_00_0_0_0_1_0_0},  // R7 blocked
        {8'h06, 1'b1, 4'b1011, 12'b0100_00_0_1_1_0_1_1},  // R9 open mode
        {8'hF3, 1'b0, 4'b0100, 12'b1000_11_1_0_0_1_0_0},  // R3 R4 R5 R7
        {8'hF3, 1'b1, 4'b0100, 12'b1000_11_1_1_0_1_0_0},  // R9 during core reset
        {8'hC9, 1'b0, 4'b1001, 12'b0010_00_1_1_1_0_0_1},  // R8 R6
        {8'h3E, 1'b0, 4'b0110, 12'b0100_11_0_1_0_1_1_0}   // R3 R4 R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {drv_sel, motor_on, core_rst, drq_oe, drq_out, dack_n_out, tc_out, intr_out};
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
        io_addr  = BASE;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        io_addr = a;
        io_rd   = 1'b1;
        #1;
        d       = io_rdata;
        io_rd   = 1'b0;
        io_addr = BASE;
        #1;
    endtask

    initial begin
        logic [7:0] rb;
        // R9: open mode passes while hardware reset is asserted.
        mode_open = 1'b1; drq_in = 1'b1; intr_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 oe in reset", drq_oe, 1);
        check("R9 intr in reset", intr_out, 1);
        // R1 / R7: gated mode in reset, enable bit cleared.
        mode_open = 1'b0;
        #1;
        check("R1 oe in reset", drq_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(BASE, rb);
        check("R1 readback", rb, 8'h00);
        check("R1 outputs", {drv_sel, motor_on, core_rst}, 7'b0001_00_1);

        // Vector table.
        for (int i = 0; i < 8; i++) begin
            logic [24:0] v;
            v = VEC[i];
            mode_open = v[16];
            {drq_in, dack_n_in, tc_in, intr_in} = v[15:12];
            wr(BASE, v[24:17]);
            check($sformatf("R3 R4 R7 R8 R9 vector %0d", i), outs(), v[11:0]);
            rd(BASE, rb);
            check($sformatf("R2 readback vector %0d", i), rb, v[24:17]);
        end

        // R2: write to another address is ignored.
        mode_open = 1'b0;
        wr(BASE, 8'h1C);
        wr(BASE + 10'd1, 8'hFF);
        rd(BASE, rb);
        check("R2 wrong address readback", rb, 8'h1C);
        check("R2 wrong address outputs", {drv_sel, motor_on, core_rst}, 7'b0001_01_0);

        // R11: read data is zero without a matching read.
        #1;
        check("R11 no read strobe", io_rdata, 8'h00);
        rd(BASE + 10'd2, rb);
        check("R11 wrong read address", rb, 8'h00);

        // R5: back-to-back 0 then 1 gives a one-cycle reset pulse.
        @(negedge clk);
        io_addr = BASE; io_wdata = 8'h18; io_wr = 1'b1;
        @(negedge clk);
        check("R5 pulse high", core_rst, 1);
        io_wdata = 8'h1C;
        @(negedge clk);
        io_wr = 1'b0;
        check("R5 pulse released", core_rst, 0);
        rd(BASE, rb);
        check("R5 R6 byte after pulse", rb, 8'h1C);

        // R6: held reset keeps the stored byte and decoded outputs.
        @(negedge clk);
        drq_in = 1'b1; dack_n_in = 1'b0; tc_in = 1'b1; intr_in = 1'b1;
        wr(BASE, 8'h39);
        repeat (3) @(negedge clk);
        rd(BASE, rb);
        check("R6 byte held in reset", rb, 8'h39);
        check("R6 outputs held in reset", outs(), 12'b0010_11_1_1_1_0_1_1);
        @(negedge clk);
        wr(BASE, 8'h3D);
        check("R5 release", core_rst, 0);

        // R4: bits 6 and 7 are stored but drive nothing.
        @(negedge clk);
        wr(BASE, 8'hDC);
        check("R4 motors with upper bits", motor_on, 2'b01);
        rd(BASE, rb);
        check("R4 upper bits readback", rb, 8'hDC);

        // R1: hardware reset mid-run clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", {drv_sel, motor_on, core_rst, drq_oe}, 8'b0001_00_1_0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(BASE, rb);
        check("R1 readback after reset", rb, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule